// File: doc/BRIEF.md
# Serial ID CRC-8 checker

The block takes a 64-bit device identifier one bit at a time, least significant bit first, and runs it through an 8-bit CRC accumulator built as a shift register with feedback. The identifier has three fields, in the order they arrive: an 8-bit family code, a 48-bit serial number and the 8-bit CRC stored with the identifier. Once all 64 bits have been accepted, the block reports in a single-cycle pulse whether the CRC checked and whether the family code matched the expected value. Both flags are then held until the next start.

The host pulses `start` before each identifier and then presents bits with a `bit_valid` strobe. Cycles without the strobe are idle and do not advance the count. After the first 56 bits the accumulator holds the CRC of the family code and serial number. The block captures that value, so the same hardware can also produce a CRC for a new identifier. The running accumulator is visible at all times.

Top module: `serial_id_crc_checker`

## Requirements
- R1: On each accepted bit the accumulator advances by the generator x^8 + x^5 + x^4 + 1 in least-significant-bit-first form. The feedback is f = acc[0] ^ bit. The new value is acc >> 1, XORed with 8'h8C when f is 1. `crc_now` always shows the accumulator.
- R2: After reset, `done`, `crc_ok`, `family_ok` and `gen_valid` are 0 and `crc_now` is 0.
- R3: `start` clears the accumulator, the bit count, `crc_ok`, `family_ok`, `gen_valid` and `gen_crc`. A `bit_valid` in the same cycle as `start` is ignored.
- R4: A cycle with `bit_valid` low changes neither the accumulator nor the bit count.
- R5: `done` is high for exactly one cycle, the cycle after the 64th accepted bit.
- R6: `crc_ok` is 1 when the accumulator is all zeros after the 64th bit, and 0 otherwise.
- R7: `family_ok` is 1 when the first 8 bits received equal 8'h09, taking the first bit as bit 0.
- R8: After the 56th accepted bit, `gen_valid` is 1 and `gen_crc` holds the accumulator value over the first 56 bits.
- R9: Once 64 bits have been accepted, further bits are ignored until the next `start`: `crc_now` stays stable and no second `done` occurs.
- R10: `crc_ok` and `family_ok` keep their values from `done` until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears the accumulator and results for a new identifier |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial identifier bit, least significant first |
| done | output | 1 | One-cycle pulse after the final bit |
| crc_ok | output | 1 | Accumulator was zero after all bits |
| family_ok | output | 1 | Family field matched the expected code |
| gen_valid | output | 1 | `gen_crc` holds the CRC of the body |
| gen_crc | output | 8 | CRC over family code and serial number |
| crc_now | output | 8 | Running accumulator value |

## Verification
The bench sweeps all 256 family codes, with serial numbers derived from each code, and corrupts the stored CRC of some identifiers. A wrong feedback tap or the wrong bit order would then make `crc_ok` fail on good identifiers or pass on bad ones. Idle gaps are placed between bits, because a counter that advanced on idle cycles would raise `done` early and compute a wrong CRC. Bits sent after the 64th, and a start that arrives together with a valid bit, expose a design that keeps shifting once it is full or that takes the first bit from the start cycle. Both show up as a changed `crc_now`, a second `done` or a failed check on the next identifier.

// File: rtl/id_chk_pkg.sv
package id_chk_pkg;
  typedef enum logic [1:0] {
    PH_FAMILY = 2'd0,
    PH_SERIAL = 2'd1,
    PH_CHECK  = 2'd2,
    PH_FULL   = 2'd3
  } id_phase_e;

  localparam int unsigned DEF_ID_BITS  = 64;
  localparam int unsigned DEF_FAM_BITS = 8;
  localparam int unsigned DEF_CRC_BITS = 8;
endpackage

// File: rtl/id_bit_sequencer.sv
module id_bit_sequencer
  import id_chk_pkg::*;
#(
  parameter int unsigned ID_BITS  = DEF_ID_BITS,
  parameter int unsigned FAM_BITS = DEF_FAM_BITS,
  parameter int unsigned CRC_BITS = DEF_CRC_BITS
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic bit_valid,
  output logic accept,
  output logic fam_shift,
  output logic body_end,
  output logic last_bit
);
  localparam int unsigned CW       = $clog2(ID_BITS + 1);
  localparam int unsigned BODY_END = ID_BITS - CRC_BITS;

  logic [CW-1:0] cnt_q;
  logic          full;
  id_phase_e     phase;

  assign full   = (cnt_q == CW'(ID_BITS));
  assign accept = bit_valid & ~start & ~full;

  always_ff @(posedge clk) begin
    if (rst || start) cnt_q <= '0;
    else if (accept)  cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    if (full)                         phase = PH_FULL;
    else if (cnt_q < CW'(FAM_BITS))   phase = PH_FAMILY;
    else if (cnt_q < CW'(BODY_END))   phase = PH_SERIAL;
    else                              phase = PH_CHECK;
  end

  assign fam_shift = accept && (phase == PH_FAMILY);
  assign body_end  = accept && (cnt_q == CW'(BODY_END - 1));
  assign last_bit  = accept && (cnt_q == CW'(ID_BITS - 1));
endmodule

// File: rtl/crc_lfsr_serial.sv
module crc_lfsr_serial #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] POLY = 8'h31
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] state,
  output logic [W-1:0] next_state
);
  logic [W-1:0] rpoly;
  logic         fb;

  // Bit-reversed generator for right-shifting, least-significant-first data.
  for (genvar g = 0; g < W; g++) begin : g_rev
    assign rpoly[g] = POLY[W-1-g];
  end

  assign fb         = state[0] ^ din;
  assign next_state = (state >> 1) ^ (fb ? rpoly : '0);

  always_ff @(posedge clk) begin
    if (rst || clear)  state <= '0;
    else if (shift_en) state <= next_state;
  end
endmodule

// File: rtl/family_capture.sv
module family_capture #(
  parameter int unsigned FAM_BITS = 8,
  parameter logic [FAM_BITS-1:0] EXPECT = 8'h09
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic shift_en,
  input  logic din,
  output logic match
);
  logic [FAM_BITS-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst || clear)  sr_q <= '0;
    else if (shift_en) sr_q <= {din, sr_q[FAM_BITS-1:1]};
  end

  assign match = (sr_q == EXPECT);
endmodule

// File: rtl/serial_id_crc_checker.sv
module serial_id_crc_checker
  import id_chk_pkg::*;
#(
  parameter int unsigned ID_BITS  = DEF_ID_BITS,
  parameter int unsigned FAM_BITS = DEF_FAM_BITS,
  parameter int unsigned CRC_BITS = DEF_CRC_BITS,
  parameter logic [CRC_BITS-1:0] POLY = 8'h31,
  parameter logic [FAM_BITS-1:0] FAMILY_CODE = 8'h09
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                bit_valid,
  input  logic                bit_in,
  output logic                done,
  output logic                crc_ok,
  output logic                family_ok,
  output logic                gen_valid,
  output logic [CRC_BITS-1:0] gen_crc,
  output logic [CRC_BITS-1:0] crc_now
);
  logic                accept, fam_shift, body_end, last_bit;
  logic                fam_match;
  logic [CRC_BITS-1:0] crc_next;

  id_bit_sequencer #(
    .ID_BITS(ID_BITS), .FAM_BITS(FAM_BITS), .CRC_BITS(CRC_BITS)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .bit_valid(bit_valid),
    .accept(accept), .fam_shift(fam_shift), .body_end(body_end),
    .last_bit(last_bit)
  );

  crc_lfsr_serial #(.W(CRC_BITS), .POLY(POLY)) u_crc (
    .clk(clk), .rst(rst), .clear(start), .shift_en(accept), .din(bit_in),
    .state(crc_now), .next_state(crc_next)
  );

  family_capture #(.FAM_BITS(FAM_BITS), .EXPECT(FAMILY_CODE)) u_fam (
    .clk(clk), .rst(rst), .clear(start), .shift_en(fam_shift), .din(bit_in),
    .match(fam_match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      crc_ok    <= 1'b0;
      family_ok <= 1'b0;
      gen_valid <= 1'b0;
      gen_crc   <= '0;
    end else if (start) begin
      done      <= 1'b0;
      crc_ok    <= 1'b0;
      family_ok <= 1'b0;
      gen_valid <= 1'b0;
      gen_crc   <= '0;
    end else begin
      done <= last_bit;
      if (last_bit) begin
        crc_ok    <= (crc_next == '0);
        family_ok <= fam_match;
      end
      if (body_end) begin
        gen_crc   <= crc_next;
        gen_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_id_crc_checker_sva.sv
module serial_id_crc_checker_sva #(
  parameter int unsigned CRC_BITS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                bit_valid,
  input logic                done,
  input logic                crc_ok,
  input logic                family_ok,
  input logic                gen_valid,
  input logic [CRC_BITS-1:0] crc_now
);
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r3_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (crc_now == '0) && !crc_ok && !family_ok && !gen_valid && !done);

  a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!bit_valid && !start) |=> $stable(crc_now));

  a_r9_full_ignores: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable(crc_now));

  a_r10_crc_ok_held: assert property (@(posedge clk) disable iff (rst)
    !$stable(crc_ok) |-> (done || $past(start)));

  a_r10_family_held: assert property (@(posedge clk) disable iff (rst)
    !$stable(family_ok) |-> (done || $past(start)));

  a_r6_rise_on_done: assert property (@(posedge clk) disable iff (rst)
    $rose(crc_ok) |-> done);
endmodule

bind serial_id_crc_checker serial_id_crc_checker_sva #(.CRC_BITS(CRC_BITS)) u_sva (
  .clk(clk), .rst(rst), .start(start), .bit_valid(bit_valid), .done(done),
  .crc_ok(crc_ok), .family_ok(family_ok), .gen_valid(gen_valid),
  .crc_now(crc_now)
);

// File: tb/serial_id_crc_checker_test.sv
module serial_id_crc_checker_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
  logic done, crc_ok, family_ok, gen_valid;
  logic [7:0] gen_crc, crc_now;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  serial_id_crc_checker uut (
    .clk(clk), .rst(rst), .start(start), .bit_valid(bit_valid), .bit_in(bit_in),
    .done(done), .crc_ok(crc_ok), .family_ok(family_ok), .gen_valid(gen_valid),
    .gen_crc(gen_crc), .crc_now(crc_now)
  );

  // CRC over the first n bits of v, least significant bit first (R1).
  function automatic logic [7:0] ref_crc(input logic [63:0] v, input int n);
    logic [7:0] c = 8'h00;
    for (int k = 0; k < n; k++) begin
      logic f = c[0] ^ v[k];
      c = c >> 1;
      if (f) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1; bit_valid = 1'b0;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_id(input logic [63:0] id, input bit gaps);
    logic [7:0] held;
    for (int i = 0; i < 64; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk); bit_valid = 1'b0;
        held = crc_now;
        @(negedge clk);
        check(crc_now == held, "R4 idle cycle", crc_now, held);
      end else begin
        @(negedge clk);
      end
      if (i == 8)
        check(crc_now == ref_crc(id, 8), "R1 crc after family", crc_now, ref_crc(id, 8));
      if (i == 60)
        check(done == 1'b0, "R5 no early done", done, 0);
      bit_valid = 1'b1; bit_in = id[i];
    end
    @(negedge clk); bit_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] id;
    logic [47:0] serial;
    logic [7:0]  body_crc;
    logic        exp_ok;
    logic [7:0]  held;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: reset state
    check(!done && !crc_ok && !family_ok && !gen_valid, "R2 flags after reset",
          {done, crc_ok, family_ok, gen_valid}, 0);
    check(crc_now == 8'h00, "R2 accumulator after reset", crc_now, 0);

    for (int f = 0; f < 256; f++) begin
      serial = {f[7:0], ~f[7:0], f[7:0] ^ 8'h5A, 8'hC3, f[7:0] + 8'd17, 8'h01};
      id[55:0] = {serial, f[7:0]};
      body_crc = ref_crc(id, 56);
      id[63:56] = body_crc;
      if (f % 8 == 3) id[56 + (f / 8) % 8] = ~id[56 + (f / 8) % 8];
      exp_ok = (ref_crc(id, 64) == 8'h00);
      do_start();
      send_id(id, f % 4 == 1);
      // R5: done in the cycle after the last bit
      check(done == 1'b1, "R5 done pulse", done, 1);
      check(crc_ok == exp_ok, "R6 crc verdict", crc_ok, exp_ok);
      check(family_ok == (f == 9), "R7 family match", family_ok, f == 9);
      check(gen_valid && gen_crc == body_crc, "R8 generated crc", gen_crc, body_crc);
      @(negedge clk);
      check(done == 1'b0, "R5 done one cycle", done, 0);
      check(crc_ok == exp_ok && family_ok == (f == 9), "R10 verdict held",
            {crc_ok, family_ok}, {exp_ok, f == 9});
    end

    // R9: bits after the 64th are ignored
    held = crc_now;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); bit_valid = 1'b1; bit_in = k[0];
      if (k > 0) check(done == 1'b0, "R9 no second done", done, 0);
    end
    @(negedge clk); bit_valid = 1'b0;
    check(crc_now == held, "R9 accumulator frozen", crc_now, held);
    check(crc_ok == exp_ok, "R10 held through extra bits", crc_ok, exp_ok);

    // R3: start with a simultaneous valid bit ignores that bit
    @(negedge clk); start = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
    @(negedge clk); start = 1'b0; bit_valid = 1'b0;
    check(crc_now == 8'h00, "R3 start clears accumulator", crc_now, 0);
    check(!crc_ok && !family_ok && !gen_valid, "R3 start clears results",
          {crc_ok, family_ok, gen_valid}, 0);
    id[55:0] = {48'h0000_0000_1234, 8'h09};
    id[63:56] = ref_crc(id, 56);
    send_id(id, 1'b0);
    check(done && crc_ok && family_ok, "R3 count restarted at zero",
          {done, crc_ok, family_ok}, 3'b111);

    // R1: all-zero body gives zero CRC
    do_start();
    send_id(64'h0, 1'b0);
    check(gen_crc == 8'h00 && crc_ok && !family_ok, "R1 zero identifier",
          {gen_crc, crc_ok, family_ok}, 10'b10);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule